// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the run of column addresses that a synchronous DRAM burst visits, one address per clock. A start strobe loads a starting column, a burst-length code, an ordering choice and the direction of the access. The block then steps through the burst. It flags the final beat and holds a busy flag high for as long as addresses are being produced.

Two orderings are supported inside the naturally aligned block of the burst. In the counting order the low bits advance and wrap. In the exchange order the low bits of the start are XORed with the beat index. A page-length burst counts through every column of the row and wraps around. It never finishes by itself, so a terminate input (burst stop or precharge) is the only way to end it, and that input ends a burst of any length. When the single-write option is set, a write issues exactly one beat. A fresh start strobe, which may come on any clock, abandons the current burst and begins the new one. Command decoding, latency delay and the data path sit outside this block.

Top module: `sdr_col_sequencer`

## Requirements
- R1: While `rst` is high and on the first clock after it, `busy` and `last_beat` are 0 and `col_out` is 0.
- R2: A clock edge that samples `start` high makes `col_out` equal the sampled `start_col` and `busy` 1 after that edge.
- R3: With `order_xor`=0, each following beat adds one to the low k bits of the column, modulo 2^k, and leaves the upper bits at the start value. k is 1, 2 and 3 for `len_code` 1, 2 and 3 (2, 4 and 8 beats). Example: start 5, 8 beats gives 5,6,7,0,1,2,3,4.
- R4: With `order_xor`=1, beat i has low k bits equal to the start's low k bits XOR i, and upper bits equal to the start value. Example: start 5, 8 beats gives 5,4,7,6,1,0,3,2.
- R5: `len_code` 0 produces a one-beat burst. The reserved codes 4, 5 and 6 do the same. In a one-beat burst, `last_beat` is 1 together with the start address.
- R6: For any burst other than page length, `last_beat` is 1 exactly on the final address. `busy` is 0 on the clock after it, unless a new start arrives.
- R7: `len_code` 7 selects page length. The column increments by one modulo 2^COL_W on every clock, whatever `order_xor` is, and `last_beat` never rises.
- R8: `term` sampled high while busy and without `start` makes `busy` 0 on the next clock. When the block is idle, `term` has no effect and `col_out` holds its value.
- R9: With `single_wr`=1, a start with `is_write`=1 yields one beat whatever the length code is. A start with `is_write`=0 keeps the programmed length.
- R10: A start that arrives during a burst restarts the sequence from the new start column, using the new length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load a new burst this clock |
| start_col | input | COL_W | Starting column of the burst |
| len_code | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=page, others=1 |
| order_xor | input | 1 | 0 = counting wrap, 1 = XOR interleave |
| is_write | input | 1 | The burst is a write |
| single_wr | input | 1 | Force writes to a single beat |
| term | input | 1 | Burst stop or precharge: end the current burst |
| col_out | output | COL_W | Column address of the current beat |
| busy | output | 1 | A beat is being presented on col_out |
| last_beat | output | 1 | col_out is the final beat of the burst |

## Verification
The bound checker watches every cycle for the following. The start column appears after each strobe. The upper column bits stay fixed within a short burst, and `last_beat` is only seen while busy and never in a page burst. After a last beat or a terminate, busy drops, and the column stays put while idle. The exact beat orders can only be shown by the bench's scenarios: counting and XOR sequences at every length, the wrap at the top of the page, the one-beat forms, and a restart in the middle of a burst.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_ONE  = 3'd0;
  localparam logic [LEN_CODE_W-1:0] LEN_TWO  = 3'd1;
  localparam logic [LEN_CODE_W-1:0] LEN_FOUR = 3'd2;
  localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {ORD_COUNT = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  is_write,
  input  logic                  single_wr,
  output logic [COL_W-1:0]      wrap_mask,
  output logic                  page_mode
);
  always_comb begin
    wrap_mask = '0;
    page_mode = 1'b0;
    if (!(single_wr && is_write)) begin
      unique case (len_code)
        LEN_TWO:   wrap_mask = COL_W'(1);
        LEN_FOUR:  wrap_mask = COL_W'(3);
        LEN_EIGHT: wrap_mask = COL_W'(7);
        LEN_PAGE: begin
          wrap_mask = '1;
          page_mode = 1'b1;
        end
        default:   wrap_mask = '0;
      endcase
    end
  end
endmodule

// File: rtl/colgen_addr_order.sv
module colgen_addr_order
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  order_e           order,
  output logic [COL_W-1:0] beat_col
);
  logic [COL_W-1:0] low_part;

  always_comb begin
    if (order == ORD_XOR) low_part = base_col ^ beat_idx;
    else                  low_part = base_col + beat_idx;
    beat_col = (base_col & ~wrap_mask) | (low_part & wrap_mask);
  end
endmodule

// File: rtl/sdr_col_sequencer.sv
module sdr_col_sequencer
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_xor,
  input  logic                  is_write,
  input  logic                  single_wr,
  input  logic                  term,
  output logic [COL_W-1:0]      col_out,
  output logic                  busy,
  output logic                  last_beat
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] base_q, mask_q, idx_q, col_q, nxt_idx, nxt_col;
  logic             page_q, busy_q, last_q;
  order_e           ord_q;

  colgen_len_dec #(.COL_W(COL_W)) len_dec_i (
    .len_code (len_code),
    .is_write (is_write),
    .single_wr(single_wr),
    .wrap_mask(dec_mask),
    .page_mode(dec_page)
  );

  assign nxt_idx = idx_q + COL_W'(1);

  colgen_addr_order #(.COL_W(COL_W)) order_i (
    .base_col (base_q),
    .beat_idx (nxt_idx),
    .wrap_mask(mask_q),
    .order    (ord_q),
    .beat_col (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      col_q  <= '0;
      page_q <= 1'b0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
      ord_q  <= ORD_COUNT;
    end else if (start) begin
      base_q <= start_col;
      mask_q <= dec_mask;
      idx_q  <= '0;
      col_q  <= start_col;
      page_q <= dec_page;
      busy_q <= 1'b1;
      last_q <= !dec_page && (dec_mask == '0);
      ord_q  <= (order_xor && !dec_page) ? ORD_XOR : ORD_COUNT;
    end else if (busy_q && (term || last_q)) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (busy_q) begin
      idx_q  <= nxt_idx;
      col_q  <= nxt_col;
      last_q <= !page_q && (nxt_idx == mask_q);
    end
  end

  assign col_out   = col_q;
  assign busy      = busy_q;
  assign last_beat = last_q;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [COL_W-1:0]      start_col,
  input logic [LEN_CODE_W-1:0] len_code,
  input logic                  is_write,
  input logic                  single_wr,
  input logic                  term,
  input logic [COL_W-1:0]      col_out,
  input logic                  busy,
  input logic                  last_beat
);
  logic page_trk;

  always_ff @(posedge clk) begin
    if (rst) page_trk <= 1'b0;
    else if (start) page_trk <= (len_code == LEN_PAGE) && !(is_write && single_wr);
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && col_out == $past(start_col)));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(start) && !page_trk)
      |-> col_out[COL_W-1:3] == $past(col_out[COL_W-1:3]));

  assert_last_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> busy);

  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !start) |=> !busy);

  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && page_trk) |-> !last_beat);

  assert_term_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && term && !start) |=> !busy);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && $stable(col_out)));
endmodule

bind sdr_col_sequencer colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .start_col(start_col),
  .len_code (len_code),
  .is_write (is_write),
  .single_wr(single_wr),
  .term     (term),
  .col_out  (col_out),
  .busy     (busy),
  .last_beat(last_beat)
);

// File: tb/sdr_col_sequencer_tb.sv
module sdr_col_sequencer_tb_top;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             order_xor = 1'b0;
  logic             is_write = 1'b0;
  logic             single_wr = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             busy, last_beat;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sdr_col_sequencer #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .order_xor(order_xor), .is_write(is_write),
    .single_wr(single_wr), .term(term), .col_out(col_out),
    .busy(busy), .last_beat(last_beat)
  );

  localparam int NV = 8;
  localparam logic [7:0]  V_COL  [NV] = '{8'h2D, 8'h2D, 8'h13, 8'h13, 8'hFF, 8'h40, 8'h9A, 8'h06};
  localparam logic [2:0]  V_CODE [NV] = '{3'd3, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd3};
  localparam logic        V_XOR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int          V_LEN  [NV] = '{8, 8, 4, 4, 2, 2, 1, 8};
  localparam logic [63:0] V_EXP  [NV] = '{
    64'h2C2B2A29_282F2E2D, 64'h2A2B2829_2E2F2C2D,
    64'h00000000_12111013, 64'h00000000_10111213,
    64'h00000000_0000FEFF, 64'h00000000_00004140,
    64'h00000000_0000009A, 64'h01000302_05040706};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [7:0] c, input logic [2:0] code, input logic ox,
                      input logic wr, input logic sw);
    start = 1'b1; start_col = c; len_code = code; order_xor = ox;
    is_write = wr; single_wr = sw;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input string req, input logic [7:0] c, input logic [2:0] code,
                           input logic ox, input logic wr, input logic sw,
                           input int len, input logic [63:0] exp);
    kick(c, code, ox, wr, sw);
    for (int b = 0; b < len; b++) begin
      chk(req, {24'd0, col_out}, {24'd0, exp[b*8 +: 8]});
      chk("R6", {31'd0, last_beat}, {31'd0, (b == len - 1)});
      chk(req, {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    chk("R6", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", {31'd0, busy}, 32'd0);
    chk("R1", {31'd0, last_beat}, 32'd0);
    chk("R1", {24'd0, col_out}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, busy}, 32'd0);

    // vector table: R3 counting order, R4 XOR order, R5 one beat
    for (int v = 0; v < NV; v++)
      run_burst(V_XOR[v] ? "R4" : "R3", V_COL[v], V_CODE[v], V_XOR[v], 1'b0, 1'b0,
                V_LEN[v], V_EXP[v]);

    // R2 start load
    kick(8'h77, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R2", {24'd0, col_out}, 32'h77);
    chk("R2", {31'd0, busy}, 32'd1);
    @(negedge clk);

    // R5 reserved length code acts as one beat
    run_burst("R5", 8'h55, 3'd5, 1'b0, 1'b0, 1'b0, 1, 64'h55);

    // R7 page burst wraps through the top, XOR request ignored
    kick(8'hFE, 3'd7, 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < 6; b++) begin
      chk("R7", {24'd0, col_out}, {24'd0, 8'(8'hFE + b)});
      chk("R7", {31'd0, last_beat}, 32'd0);
      @(negedge clk);
    end
    // R8 terminate ends the page burst
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R8", {31'd0, busy}, 32'd0);
    chk("R8", {24'd0, col_out}, 32'h04);
    // R8 terminate while idle is ignored
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    @(negedge clk);
    chk("R8", {31'd0, busy}, 32'd0);
    chk("R8", {24'd0, col_out}, 32'h04);

    // R8 terminate in a short burst
    kick(8'h20, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8", {24'd0, col_out}, 32'h21);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R8", {31'd0, busy}, 32'd0);

    // R9 single write: write is one beat, read keeps its length
    run_burst("R9", 8'h31, 3'd3, 1'b0, 1'b1, 1'b1, 1, 64'h31);
    run_burst("R9", 8'h31, 3'd2, 1'b0, 1'b0, 1'b1, 4, 64'h30333231);
    run_burst("R9", 8'h31, 3'd7, 1'b0, 1'b1, 1'b1, 1, 64'h31);

    // R10 restart during a burst
    kick(8'h2D, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10", {24'd0, col_out}, 32'h2E);
    run_burst("R10", 8'h13, 3'd2, 1'b1, 1'b0, 1'b0, 4, 64'h10111213);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule